// File: doc/BRIEF.md
# Memory-Write Activity Hit Counter

This block watches memory write cycles for a power-management unit and decides when enough of them have landed inside a chosen address window to count as system activity. Each write strobe with an address that falls inside the inclusive window set by a lower and an upper bound adds one to a hit count. When the count reaches a limit that a 3-bit code selects as a power of two, the block emits a one-cycle activity pulse. It then starts over from zero.

The count only survives while the power manager stays in one quiet state. An expiry pulse from the state-transition timer clears it. So does a pulse for any other detected activity. A run of writes therefore only counts when it fits inside a single state with nothing else going on. A separate enable input switches the whole function off. The bound registers and the power-state machine sit outside the block.

Top module: `mwa_activity_monitor`

## Requirements
- R1: While rst_ni is low, activity_o is 0 and the hit count is zero. The first report after reset needs a full run of hits.
- R2: A write counts as a hit only when lo_bound_i <= wr_addr_i <= hi_bound_i (unsigned, both bounds inclusive). Writes below the lower bound or above the upper bound change nothing.
- R3: The hit limit is 2 raised to limit_code_i: code 0 gives 1, code 1 gives 2, and so on up to code 7, which gives 128. The activity pulse comes in the cycle after the clock edge on which the hit that brings the count to the limit is sampled.
- R4: activity_o is a registered pulse that lasts one cycle for each report. On the same edge that reports, the count returns to zero, so the next report needs a fresh run of limit hits.
- R5: A state_expire_i pulse clears the hit count to zero.
- R6: An other_act_i pulse clears the hit count to zero.
- R7: When a clear (state_expire_i or other_act_i) and an in-window write are sampled on the same edge, the clear wins. The write is not counted and no activity is reported.
- R8: While enable_i is 0, nothing is counted, no activity is reported and the count is held at zero.
- R9: When wr_valid_i is 0, the value on wr_addr_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Function enable |
| limit_code_i | input | 3 | Hit limit select; the limit is 2^code |
| lo_bound_i | input | 16 | Lower window bound, inclusive |
| hi_bound_i | input | 16 | Upper window bound, inclusive |
| wr_valid_i | input | 1 | Memory write strobe, one cycle per write |
| wr_addr_i | input | 16 | Address of the memory write |
| state_expire_i | input | 1 | Power-state timer expiry pulse |
| other_act_i | input | 1 | Pulse for any other detected activity |
| activity_o | output | 1 | One-cycle activity report |

## Verification
Two things can land on the same edge: an in-window write that would raise the count, and a clear from either timer expiry or other activity. The bench puts them together on purpose in several cases. One case has the limit at 1, so the write on its own would report at once. Other cases come partway through a run of hits. The bench expects no pulse, and it expects the following run to need the full limit again, which shows that the count really was cleared. A long random phase also lets strobes, clears and enable drops overlap freely. There the behavioural model judges every cycle.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned CNT_W   = 2 ** CODE_W;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_CLEAR  = 2'd1,
    CNT_INC    = 2'd2,
    CNT_REPORT = 2'd3
  } cnt_action_e;
endpackage

// File: rtl/mwa_window.sv
module mwa_window #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] lo_bound_i,
  input  logic [ADDR_W-1:0] hi_bound_i,
  output logic              hit_o
);
  logic above_lo, below_hi;

  assign above_lo = (wr_addr_i >= lo_bound_i);
  assign below_hi = (wr_addr_i <= hi_bound_i);
  assign hit_o    = wr_valid_i & above_lo & below_hi;
endmodule

// File: rtl/mwa_limit_dec.sv
module mwa_limit_dec #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = 2 ** CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  limit_o
);
  // one-hot limit: bit i set when code == i
  for (genvar i = 0; i < CNT_W; i++) begin : g_dec
    assign limit_o[i] = (code_i == CODE_W'(i));
  end
endmodule

// File: rtl/mwa_hit_counter.sv
module mwa_hit_counter
  import mwa_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         clear_i,
  input  logic         hit_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] count_o,
  output logic         report_o
);
  logic [W-1:0] count_q;
  logic         report_q;
  logic [W:0]   count_inc;
  logic         reach;
  cnt_action_e  action;

  assign count_inc = {1'b0, count_q} + (W+1)'(1);
  assign reach     = (count_inc >= {1'b0, limit_i});

  always_comb begin
    if (!enable_i || clear_i) action = CNT_CLEAR;
    else if (hit_i && reach)  action = CNT_REPORT;
    else if (hit_i)           action = CNT_INC;
    else                      action = CNT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      report_q <= 1'b0;
    end else begin
      report_q <= (action == CNT_REPORT);
      unique case (action)
        CNT_CLEAR, CNT_REPORT: count_q <= '0;
        CNT_INC:               count_q <= count_inc[W-1:0];
        default:               count_q <= count_q;
      endcase
    end
  end

  assign count_o  = count_q;
  assign report_o = report_q;

  a_r4_report_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    report_q |-> (count_q == '0));
  a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!report_q && count_q == '0));
  a_r8_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!report_q && count_q == '0));
endmodule

// File: rtl/mwa_activity_monitor.sv
module mwa_activity_monitor
  import mwa_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CODE_W,
  localparam int unsigned LW = 2 ** CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [CW-1:0] limit_code_i,
  input  logic [AW-1:0] lo_bound_i,
  input  logic [AW-1:0] hi_bound_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          state_expire_i,
  input  logic          other_act_i,
  output logic          activity_o
);
  logic          hit;
  logic          clear;
  logic [LW-1:0] limit;
  logic [LW-1:0] count;

  assign clear = state_expire_i | other_act_i;

  mwa_window #(.ADDR_W(AW)) i_window (
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .lo_bound_i (lo_bound_i),
    .hi_bound_i (hi_bound_i),
    .hit_o      (hit)
  );

  mwa_limit_dec #(.CODE_W(CW)) i_limit_dec (
    .code_i  (limit_code_i),
    .limit_o (limit)
  );

  mwa_hit_counter #(.W(LW)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .clear_i  (clear),
    .hit_i    (hit),
    .limit_i  (limit),
    .count_o  (count),
    .report_o (activity_o)
  );

  // R3: every report traces to an uncleared in-window write on the prior edge
  a_r3_report_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_o |-> $past(wr_valid_i && enable_i && !state_expire_i && !other_act_i));
  a_r2_out_of_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !clear && wr_valid_i && (wr_addr_i < lo_bound_i || wr_addr_i > hi_bound_i))
      |=> !activity_o && $stable(count));
  a_r3_limit_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(limit) && (limit != '0));
endmodule

// File: tb/test_mwa_activity_monitor.sv
module test_mwa_activity_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [2:0]    code = '0;
  logic [AW-1:0] lo = 16'h0100;
  logic [AW-1:0] hi = 16'h01FF;
  logic          wv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          expire = 1'b0;
  logic          other = 1'b0;
  logic          act;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  int mdl_cnt = 0;
  bit mdl_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwa_activity_monitor i_mwa_activity_monitor (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .limit_code_i(code),
    .lo_bound_i(lo), .hi_bound_i(hi), .wr_valid_i(wv), .wr_addr_i(addr),
    .state_expire_i(expire), .other_act_i(other), .activity_o(act)
  );

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s activity_o=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_cnt = 0;
      mdl_act = 0;
    end else begin
      bit inwin;
      inwin = wv && (addr >= lo) && (addr <= hi);
      mdl_act = 0;
      if (!en || expire || other) mdl_cnt = 0;
      else if (inwin) begin
        mdl_cnt = mdl_cnt + 1;
        if (mdl_cnt >= (1 << code)) begin
          mdl_act = 1;
          mdl_cnt = 0;
        end
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) if (rst_n && !done) check(act, mdl_act, tag);

  task automatic step(input bit v, input logic [AW-1:0] a, input bit ex, input bit ot);
    wv = v; addr = a; expire = ex; other = ot;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, '0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(act, 1'b0, "R1");
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);

    // R3: every limit code, back-to-back hits
    tag = "R3";
    for (int c = 0; c < 8; c++) begin
      code = 3'(c);
      for (int k = 0; k < (1 << c); k++) step(1, 16'h0140, 0, 0);
      idle(2);
    end
    // R3: spaced hits with code 2
    code = 3'd2;
    for (int k = 0; k < 4; k++) begin step(1, 16'h0180, 0, 0); idle(1); end
    idle(1);

    // R2: window boundaries, code 1
    tag = "R2";
    code = 3'd1;
    step(1, 16'h00FF, 0, 0);
    step(1, 16'h0200, 0, 0);
    step(1, 16'h0200, 0, 0);
    idle(1);
    check(act, 1'b0, "R2");
    step(1, 16'h0100, 0, 0);
    step(1, 16'h01FF, 0, 0);
    check(act, 1'b1, "R2");
    idle(2);

    // R9: strobe low ignores address
    tag = "R9";
    code = 3'd0;
    for (int k = 0; k < 5; k++) step(0, 16'h0150, 0, 0);
    check(act, 1'b0, "R9");
    idle(1);

    // R5: expiry clears a partial run
    tag = "R5";
    code = 3'd2;
    for (int k = 0; k < 3; k++) step(1, 16'h0120, 0, 0);
    step(0, '0, 1, 0);
    for (int k = 0; k < 3; k++) step(1, 16'h0120, 0, 0);
    check(act, 1'b0, "R5");
    step(1, 16'h0120, 0, 0);
    check(act, 1'b1, "R5");
    idle(2);

    // R6: other activity clears a partial run
    tag = "R6";
    for (int k = 0; k < 3; k++) step(1, 16'h0120, 0, 0);
    step(0, '0, 0, 1);
    for (int k = 0; k < 3; k++) step(1, 16'h0120, 0, 0);
    check(act, 1'b0, "R6");
    step(1, 16'h0120, 0, 0);
    check(act, 1'b1, "R6");
    idle(2);

    // R7: clear and hit on the same edge
    tag = "R7";
    code = 3'd0;
    step(1, 16'h0100, 1, 0);
    check(act, 1'b0, "R7");
    step(1, 16'h0100, 0, 1);
    check(act, 1'b0, "R7");
    code = 3'd1;
    step(1, 16'h0100, 0, 0);
    step(1, 16'h0100, 1, 0);
    step(1, 16'h0100, 0, 0);
    check(act, 1'b0, "R7");
    step(1, 16'h0100, 0, 0);
    check(act, 1'b1, "R7");
    idle(2);

    // R8: disabled
    tag = "R8";
    en = 1'b0;
    code = 3'd0;
    for (int k = 0; k < 4; k++) step(1, 16'h0100, 0, 0);
    check(act, 1'b0, "R8");
    en = 1'b1;
    code = 3'd2;
    for (int k = 0; k < 3; k++) step(1, 16'h0100, 0, 0);
    en = 1'b0;
    step(0, '0, 0, 0);
    en = 1'b1;
    step(1, 16'h0100, 0, 0);
    check(act, 1'b0, "R8");
    idle(2);

    // R4: pulse per report and fresh run afterwards
    tag = "R4";
    code = 3'd0;
    for (int k = 0; k < 4; k++) step(1, 16'h0110, 0, 0);
    idle(1);
    code = 3'd1;
    for (int k = 0; k < 4; k++) step(1, 16'h0110, 0, 0);
    check(act, 1'b1, "R4");
    step(1, 16'h0110, 0, 0);
    check(act, 1'b0, "R4");
    idle(2);

    // random mix, judged by the model each cycle
    tag = "R3";
    lo = 16'h0040; hi = 16'h00C0;
    for (int k = 0; k < 3000; k++) begin
      if (k % 400 == 0) code = 3'($urandom_range(0, 4));
      en = ($urandom_range(0, 99) != 0);
      step(($urandom_range(0, 3) != 0), 16'($urandom_range(0, 255)),
           ($urandom_range(0, 60) == 0), ($urandom_range(0, 60) == 0));
    end
    idle(2);

    // R1: asynchronous reset mid-run
    tag = "R1";
    code = 3'd1;
    step(1, 16'h0050, 0, 0);
    rst_n = 1'b0;
    #1 check(act, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 16'h0050, 0, 0);
    check(act, 1'b0, "R1");
    step(1, 16'h0050, 0, 0);
    check(act, 1'b1, "R1");
    idle(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule